// File: doc/BRIEF.md
# Entropy-Based Pattern Selector

The selector decides, one candidate at a time, whether a pattern earns a slot in a pattern-matching bank. Each candidate arrives as an occurrence count with its pattern index. The block turns the count into a probability p (count over the total number of samples) and takes a table-based negative base-2 logarithm of p. It then forms a cost-weighted information score and emits a keep/drop flag together with the same index. The score uses one of two formulas, chosen by where p lies relative to the ratio of the acceptance-rate budget W to the bank capacity N. Below that ratio the score grows with p·N. At or above it the rate budget caps it at W.

Candidates stream in and out on valid/ready handshakes. A candidate moves on input when `in_valid` and `in_ready` are both high at a clock edge, and a result moves on output when `out_valid` and `out_ready` are both high. The pipeline advances only while its last stage is empty or being drained. So `in_ready` drops exactly when a result is waiting and `out_ready` is low, and it returns in the cycle the sink accepts. Nothing is lost or reordered. The configuration pins (total, N, W, threshold) are plain levels and must stay steady while candidates are in flight.

Top module: `entropy_selector`

## Requirements
- R1: The probability is p = floor(min(count,total)·2^PF / total), an unsigned fraction with PF fraction bits, so counts above the total saturate to p = 1.0 (value 2^PF).
- R2: The log term is nl = (PF−k)·2^LF − T[i]. Here k is the bit position of the leading one of p, and i is the LB bits just below that leading one, with zeros filled in when fewer bits exist. T[i] = round(2^LF·log2(1 + i/2^LB)).
- R3: When p·N < W·2^PF, the score is floor(p·N·nl / 2^PF).
- R4: When p·N ≥ W·2^PF (equality included), the score is W·nl; in particular p = 1.0 always scores zero.
- R5: `out_keep` is 1 exactly when the score is strictly greater than `cfg_thresh`, so a threshold equal to the score drops the pattern.
- R6: A zero count, a zero total, or a p that floors to zero always gives `out_keep` = 0, whatever the threshold.
- R7: With `out_ready` held high, `out_valid` for a candidate rises PF+4 clock edges after the edge that accepted it, and `out_idx` carries that candidate's index.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_idx`/`out_keep` hold. Results leave in input order with none lost.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1, and a reset clears candidates that were in flight.
- R10: With `out_ready` held high, `in_ready` stays high, so one candidate is accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Candidate present |
| in_ready | output | 1 | Block can take a candidate this cycle |
| in_count | input | CW | Occurrence count of the candidate |
| in_idx | input | IW | Pattern index, returned with the result |
| cfg_total | input | CW | Total sample count (denominator of p) |
| cfg_slots | input | NW | Bank capacity N |
| cfg_rate | input | WW | Acceptance-rate budget W |
| cfg_thresh | input | SW | Score threshold, LF fraction bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_idx | output | IW | Index of the candidate |
| out_keep | output | 1 | 1 = put pattern in the bank |

## Verification
The bench builds the selector with PF = 8, LB = 4, LF = 8 and 12-bit counts, N and W. With these values a 256-sample total reaches every table index, every shift amount, and the zero-padded case where the leading one sits below bit LB. Small counts over a total of 1000 make p floor to zero. Twelve-bit N and W allow vectors on both sides of the W/N boundary and exactly on it. Each scored vector is run with the threshold one below the score and then equal to it, which pins the score to the exact value.

// File: rtl/sel_pkg.sv
package sel_pkg;

  // Entry i of the mantissa log table: round(2^lf * log2(1 + i/2^lb)).
  function automatic int mant_log_entry(input int i, input int lb, input int lf);
    real frac;
    real lg;
    frac = 1.0 + real'(i) / real'(1 << lb);
    lg   = $ln(frac) / $ln(2.0);
    return $rtoi(lg * real'(1 << lf) + 0.5);
  endfunction

endpackage

// File: rtl/sel_divider.sv
// Pipelined restoring divider: one quotient bit per stage, PF+1 stages.
// Requires num <= den and den != 0 (enforced by the caller).
module sel_divider #(
  parameter int CW = 16,
  parameter int PF = 12,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  input  logic [CW-1:0] in_num,
  input  logic [CW-1:0] den,
  input  logic [TW-1:0] in_tag,
  output logic          out_valid,
  output logic [PF:0]   out_quo,
  output logic [TW-1:0] out_tag
);

  localparam int RW = CW + 1;

  logic [RW-1:0] den_x;
  assign den_x = {1'b0, den};

  for (genvar s = 0; s <= PF; s++) begin : g_st
    logic [RW-1:0] r_in;
    logic [PF:0]   q_in;
    logic          v_in;
    logic [TW-1:0] t_in;
    logic [RW-1:0] trial;
    logic          take;
    logic          vld_r;
    logic [PF:0]   quo_r;
    logic [TW-1:0] tag_r;

    if (s == 0) begin : g_first
      assign r_in  = {1'b0, in_num};
      assign q_in  = '0;
      assign v_in  = in_valid;
      assign t_in  = in_tag;
      assign trial = r_in;
    end else begin : g_next
      assign r_in  = g_st[s-1].g_rem.rem_r;
      assign q_in  = g_st[s-1].quo_r;
      assign v_in  = g_st[s-1].vld_r;
      assign t_in  = g_st[s-1].tag_r;
      assign trial = r_in << 1;
    end

    assign take = (trial >= den_x);

    always_ff @(posedge clk) begin
      if (!rst_n) vld_r <= 1'b0;
      else if (en) vld_r <= v_in;
    end

    always_ff @(posedge clk) begin
      if (en) begin
        quo_r <= (q_in << 1) | (PF+1)'(take);
        tag_r <= t_in;
      end
    end

    if (s < PF) begin : g_rem
      logic [RW-1:0] rem_r;
      always_ff @(posedge clk) begin
        if (en) rem_r <= take ? (trial - den_x) : trial;
      end
    end
  end

  assign out_valid = g_st[PF].vld_r;
  assign out_quo   = g_st[PF].quo_r;
  assign out_tag   = g_st[PF].tag_r;

  // R1: a clamped count never yields a probability above 1.0
  p_quot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_quo <= (PF+1)'(1 << PF)));

endmodule

// File: rtl/sel_neglog.sv
// Leading-one normalisation plus table lookup: -log2(p) with LF fraction bits.
module sel_neglog #(
  parameter int PF  = 12,
  parameter int LB  = 4,
  parameter int LF  = 8,
  parameter int TW  = 8,
  localparam int KW  = $clog2(PF + 1),
  localparam int NLW = KW + LF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           in_valid,
  input  logic [PF:0]    in_p,
  input  logic [TW-1:0]  in_tag,
  output logic           out_valid,
  output logic [PF:0]    out_p,
  output logic [NLW-1:0] out_nl,
  output logic [TW-1:0]  out_tag
);

  localparam int ENT = 1 << LB;

  logic [LF:0] mant_tab [ENT];
  for (genvar g = 0; g < ENT; g++) begin : g_tab
    assign mant_tab[g] = (LF+1)'(sel_pkg::mant_log_entry(g, LB, LF));
  end

  logic [KW-1:0]  lead;
  logic [KW-1:0]  shamt;
  logic [PF:0]    norm;
  logic [LB-1:0]  slot;
  logic [NLW-1:0] nl_c;
  logic           p_zero;

  always_comb begin
    lead = '0;
    for (int j = 0; j <= PF; j++) begin
      if (in_p[j]) lead = KW'(j);
    end
  end

  assign shamt  = KW'(PF) - lead;
  assign norm   = in_p << shamt;
  assign slot   = LB'(norm >> (PF - LB));
  assign nl_c   = {shamt, {LF{1'b0}}} - NLW'(mant_tab[slot]);
  assign p_zero = (in_p == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (en) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_p   <= in_p;
      out_nl  <= nl_c;
      out_tag <= {in_tag[TW-1:1], in_tag[0] | p_zero};
    end
  end

  // R2: log term never exceeds the smallest-probability value
  p_nl_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nl <= NLW'(PF << LF)));
  // R2: p = 1.0 gives a zero log term
  p_nl_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_p == (PF+1)'(1 << PF)) |-> (out_nl == '0));

endmodule

// File: rtl/sel_score.sv
// Branch selection at p = W/N, weighted score, threshold compare.
module sel_score #(
  parameter int PF  = 12,
  parameter int NW  = 16,
  parameter int WW  = 16,
  parameter int NLW = 12,
  parameter int SW  = 29,
  parameter int TW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           in_valid,
  input  logic [PF:0]    in_p,
  input  logic [NLW-1:0] in_nl,
  input  logic [TW-1:0]  in_tag,
  input  logic [NW-1:0]  slots,
  input  logic [WW-1:0]  rate,
  input  logic [SW-1:0]  thresh,
  output logic           out_valid,
  output logic           out_keep,
  output logic [TW-1:0]  out_tag
);

  localparam int PNW = PF + 1 + NW;
  localparam int LOW = PNW + NLW;
  localparam int CMW = ((PNW > WW + PF) ? PNW : WW + PF) + 1;

  logic [PNW-1:0] pn;
  logic [CMW-1:0] lim;
  logic           cap_branch;
  logic [LOW-1:0] lo_full;
  logic [SW-1:0]  lo_sc;
  logic [SW-1:0]  hi_sc;
  logic [SW-1:0]  sc_c;

  assign pn         = PNW'(in_p) * PNW'(slots);
  assign lim        = CMW'({rate, {PF{1'b0}}});
  assign cap_branch = (CMW'(pn) >= lim);
  assign lo_full    = LOW'(pn) * LOW'(in_nl);
  assign lo_sc      = SW'(lo_full >> PF);
  assign hi_sc      = SW'(rate) * SW'(in_nl);
  assign sc_c       = cap_branch ? hi_sc : lo_sc;

  logic          v1;
  logic [SW-1:0] sc1;
  logic [TW-1:0] tag1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
    end else if (en) begin
      v1        <= in_valid;
      out_valid <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sc1      <= sc_c;
      tag1     <= in_tag;
      out_keep <= !tag1[0] && (sc1 > thresh);
      out_tag  <= tag1;
    end
  end

  // R4: probability 1.0 scores zero in whichever branch is taken
  p_unit_score_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_valid && in_p == (PF+1)'(1 << PF)) |=> (sc1 == '0));

endmodule

// File: rtl/entropy_selector.sv
module entropy_selector #(
  parameter int CW = 16,
  parameter int IW = 18,
  parameter int PF = 12,
  parameter int NW = 16,
  parameter int WW = 16,
  parameter int LB = 4,
  parameter int LF = 8,
  localparam int NLW = $clog2(PF + 1) + LF,
  localparam int SW  = ((NW + 1 > WW) ? NW + 1 : WW) + NLW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_count,
  input  logic [IW-1:0] in_idx,
  input  logic [CW-1:0] cfg_total,
  input  logic [NW-1:0] cfg_slots,
  input  logic [WW-1:0] cfg_rate,
  input  logic [SW-1:0] cfg_thresh,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_idx,
  output logic          out_keep
);

  // tag = {index, zero-flag}
  localparam int TW = IW + 1;

  logic en;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  // input stage: clamp count, flag zero cases, guard the denominator
  logic [CW-1:0] den_eff;
  logic [CW-1:0] num_c;
  logic          zero_c;
  assign den_eff = (cfg_total == '0) ? CW'(1) : cfg_total;
  assign num_c   = (in_count > den_eff) ? den_eff : in_count;
  assign zero_c  = (in_count == '0) || (cfg_total == '0);

  logic          s0_v;
  logic [CW-1:0] s0_num;
  logic [TW-1:0] s0_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) s0_v <= 1'b0;
    else if (en) s0_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s0_num <= (zero_c) ? '0 : num_c;
      s0_tag <= {in_idx, zero_c};
    end
  end

  logic          dv_v;
  logic [PF:0]   dv_p;
  logic [TW-1:0] dv_tag;

  sel_divider #(.CW(CW), .PF(PF), .TW(TW)) u_div (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_valid(s0_v), .in_num(s0_num), .den(den_eff), .in_tag(s0_tag),
    .out_valid(dv_v), .out_quo(dv_p), .out_tag(dv_tag)
  );

  logic           lg_v;
  logic [PF:0]    lg_p;
  logic [NLW-1:0] lg_nl;
  logic [TW-1:0]  lg_tag;

  sel_neglog #(.PF(PF), .LB(LB), .LF(LF), .TW(TW)) u_log (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_valid(dv_v), .in_p(dv_p), .in_tag(dv_tag),
    .out_valid(lg_v), .out_p(lg_p), .out_nl(lg_nl), .out_tag(lg_tag)
  );

  logic [TW-1:0] sc_tag;

  sel_score #(.PF(PF), .NW(NW), .WW(WW), .NLW(NLW), .SW(SW), .TW(TW)) u_sc (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_valid(lg_v), .in_p(lg_p), .in_nl(lg_nl), .in_tag(lg_tag),
    .slots(cfg_slots), .rate(cfg_rate), .thresh(cfg_thresh),
    .out_valid(out_valid), .out_keep(out_keep), .out_tag(sc_tag)
  );

  assign out_idx = sc_tag[TW-1:1];

  // R8: a stalled result holds until the sink takes it
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_keep)));

endmodule

// File: tb/tb_entropy_selector.sv
module tb_entropy_selector;

  localparam int B_CW  = 12;
  localparam int B_IW  = 8;
  localparam int B_PF  = 8;
  localparam int B_NW  = 12;
  localparam int B_WW  = 12;
  localparam int B_LB  = 4;
  localparam int B_LF  = 8;
  localparam int B_NLW = $clog2(B_PF + 1) + B_LF;
  localparam int B_SW  = ((B_NW + 1 > B_WW) ? B_NW + 1 : B_WW) + B_NLW;
  localparam int LAT   = B_PF + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [B_CW-1:0] in_count = '0;
  logic [B_IW-1:0] in_idx = '0;
  logic [B_CW-1:0] cfg_total = '0;
  logic [B_NW-1:0] cfg_slots = '0;
  logic [B_WW-1:0] cfg_rate = '0;
  logic [B_SW-1:0] cfg_thresh = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [B_IW-1:0] out_idx;
  logic out_keep;

  always #2 clk = ~clk;

  entropy_selector #(.CW(B_CW), .IW(B_IW), .PF(B_PF), .NW(B_NW), .WW(B_WW),
                     .LB(B_LB), .LF(B_LF)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_count(in_count), .in_idx(in_idx), .cfg_total(cfg_total),
    .cfg_slots(cfg_slots), .cfg_rate(cfg_rate), .cfg_thresh(cfg_thresh),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_keep(out_keep)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference score from the requirements; -1 means "always dropped" (R6).
  function automatic longint model(input longint c, input longint t, input longint n,
                                   input longint w, output bit cap);
    longint cc, p, pn, i, tv, nl, sh;
    int k;
    cap = 0;
    if (c == 0 || t == 0) return -1;
    cc = (c > t) ? t : c;
    p  = (cc << B_PF) / t;                            // R1
    if (p == 0) return -1;
    k = 0;
    for (int j = 0; j <= B_PF; j++) if ((p >> j) & 1) k = j;
    sh = B_PF - k;
    pn = p << sh;
    i  = (pn >> (B_PF - B_LB)) & ((1 << B_LB) - 1);
    tv = $rtoi($ln(1.0 + real'(i) / real'(1 << B_LB)) / $ln(2.0) * real'(1 << B_LF) + 0.5);
    nl = sh * (1 << B_LF) - tv;                       // R2
    if (p * n >= (w << B_PF)) begin cap = 1; return w * nl; end   // R4
    return (p * n * nl) >> B_PF;                      // R3
  endfunction

  // call just after a rising edge; returns just after the accepting edge
  task automatic send(input longint c, input int id, output int tries);
    bit ok;
    in_valid = 1'b1;
    in_count = B_CW'(c);
    in_idx   = B_IW'(id);
    tries = 0;
    do begin
      @(negedge clk); ok = in_ready; tries++;
      @(posedge clk); #1;
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input longint c, input longint t, input longint n, input longint w,
                         input longint thr, input int id, input bit exp_keep, input string req);
    int tries;
    int lat;
    cfg_total  = B_CW'(t);
    cfg_slots  = B_NW'(n);
    cfg_rate   = B_WW'(w);
    cfg_thresh = B_SW'(thr);
    out_ready  = 1'b1;
    send(c, id, tries);
    lat = 0;
    forever begin
      @(negedge clk);
      if (out_valid || lat > 4 * LAT) break;
      lat++;
    end
    check("R7 latency", lat, LAT);
    check("R7 index", out_idx, id);
    check(req, out_keep, exp_keep);
    @(posedge clk); #1;
  endtask

  // stimulus table: count, total, N, W
  localparam int NV = 12;
  localparam longint V_C [NV] = '{1, 128, 200, 300, 5, 5, 3, 0, 50, 999, 17, 1};
  localparam longint V_T [NV] = '{256, 256, 256, 256, 7, 256, 1000, 500, 0, 1000, 300, 1};
  localparam longint V_N [NV] = '{100, 10, 3, 40, 1000, 20, 4000, 100, 100, 2, 2500, 1};
  localparam longint V_W [NV] = '{50, 5, 2, 7, 900, 3, 5, 10, 10, 1, 60, 1};

  // streaming phase data
  localparam int NS = 24;
  longint exp_keep_q [NS];
  int     exp_idx_q  [NS];
  int     sink_mode = 0;

  task automatic stream_phase(input int mode);
    sink_mode  = mode;
    cfg_total  = B_CW'(1000);
    cfg_slots  = B_NW'(300);
    cfg_rate   = B_WW'(40);
    cfg_thresh = B_SW'(2000);
    for (int i = 0; i < NS; i++) begin
      bit cap;
      longint s;
      s = model((i * 53) % 1200, 1000, 300, 40, cap);
      exp_idx_q[i]  = 100 + i;
      exp_keep_q[i] = (s >= 0 && s > 2000) ? 1 : 0;
    end
    fork
      begin
        for (int i = 0; i < NS; i++) begin
          int tries;
          send((i * 53) % 1200, 100 + i, tries);
          if (mode == 0) check("R10 accept every cycle", tries, 1);
        end
      end
      begin
        int got = 0;
        int cyc = 0;
        bit prev_stall = 0;
        int prev_idx = 0;
        while (got < NS) begin
          @(posedge clk); #1;
          cyc++;
          out_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
          @(negedge clk);
          if (prev_stall) begin
            check("R8 stalled valid", out_valid, 1);
            check("R8 stalled index", out_idx, prev_idx);
          end
          if (out_valid && !out_ready) check("R8 in_ready low", in_ready, 0);
          prev_stall = out_valid && !out_ready;
          prev_idx   = out_idx;
          if (out_valid && out_ready) begin
            check("R8 order", out_idx, exp_idx_q[got]);
            check("R5 stream keep", out_keep, exp_keep_q[got]);
            got++;
          end
        end
      end
    join
    @(posedge clk); #1;
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R7: watchdog expired got 0 expected 1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset out_valid", out_valid, 0);
    check("R9 reset in_ready", in_ready, 1);
    @(posedge clk); #1;

    // table walk: threshold one below the score keeps, equal drops
    for (int v = 0; v < NV; v++) begin
      bit cap;
      longint s;
      string br;
      s  = model(V_C[v], V_T[v], V_N[v], V_W[v], cap);
      br = cap ? "R4 capped branch" : "R3 low branch";
      if (s > 0) begin
        run_one(V_C[v], V_T[v], V_N[v], V_W[v], s - 1, v, 1'b1, br);
        run_one(V_C[v], V_T[v], V_N[v], V_W[v], s, v + 64, 1'b0, "R5 equal threshold drops");
      end else if (s == 0) begin
        run_one(V_C[v], V_T[v], V_N[v], V_W[v], 0, v, 1'b0, "R4 unit probability");
      end else begin
        run_one(V_C[v], V_T[v], V_N[v], V_W[v], 0, v, 1'b0, "R6 zero case dropped");
      end
    end

    // R6 with the lowest threshold on a nonzero count that floors to zero
    run_one(1, 4000, 4000, 1, 0, 200, 1'b0, "R6 p floors to zero");
    // R1 clamp: count above total behaves as p = 1.0, score 0
    run_one(4000, 9, 50, 4000, 0, 201, 1'b0, "R1 clamp to one");

    stream_phase(0);
    stream_phase(1);

    // R8/R9: stall a result, then reset mid-flight
    out_ready = 1'b0;
    cfg_total = B_CW'(256); cfg_slots = B_NW'(100); cfg_rate = B_WW'(50);
    cfg_thresh = '0;
    begin
      int tries;
      send(1, 7, tries);
      send(2, 8, tries);
    end
    repeat (LAT + 2) @(negedge clk);
    check("R8 held valid", out_valid, 1);
    check("R8 held index", out_idx, 7);
    check("R8 in_ready low while held", in_ready, 0);
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 flush out_valid", out_valid, 0);
    check("R9 flush in_ready", in_ready, 1);
    repeat (LAT + 3) begin
      @(negedge clk);
      check("R9 nothing emerges after reset", out_valid, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule